// File: doc/BRIEF.md
# Hot-plug drive slot sideband controller

This block looks after the sideband pins of one hot-pluggable drive bay and the slot control and status bits that software uses for it. The raw, active-low presence pin is filtered into a stable presence state. That state drives power and reset sequencing for the drive. Insertion needs no button press: a change in the filtered presence state is enough to start the add flow. Removal is treated as a surprise event.

The block records presence changes and link-state changes, taken from an in-band link-up indication, as sticky status bits. One interrupt line summarises them. The block also flags a surprise-down error when the link is lost while the drive is in service, or when the drive leaves while the link is still up. A control bit decides whether that error is reported upward or hidden. Software reaches capability, control and status through a small synchronous register port with a combinational read.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, `pwr_dis_o`=1, `perst_n_o`=0, `dual_port_en_o`=0, `sd_err_o`=0 and `irq_o`=0, and the control and status registers read 0 while the slot is empty.
- R2: `prsnt_n_i` low means a drive is seated. The filtered presence state, status bit 4, takes a new value only after the input has held that level for DEB_CYCLES consecutive samples. It becomes visible DEB_CYCLES+1 clock edges after the input changes. A shorter pulse leaves the state unchanged.
- R3: Power is allowed when control bit 2 is set, or when no power controller is fitted. If power is allowed and the filtered state shows a drive, `pwr_dis_o` falls one edge later. `perst_n_o` then rises RST_DELAY edges after that.
- R4: When the presence state clears or power is withdrawn, `perst_n_o` falls one edge later and `pwr_dis_o` rises on the following edge.
- R5: `dual_port_en_o` is 1 only while power is applied and `dual_port_i` reports a dual-port drive.
- R6: Status bit 0 (presence changed) and status bit 1 (link changed) are set by an event only when the slot is hot-plug capable and the matching enable is set. The enable for bit 0 is control bit 0 and the enable for bit 1 is control bit 1. Each bit stays set until software writes 1 to it at address 2.
- R7: `irq_o` is the OR of status bits 0 and 1, each qualified by its enable bit.
- R8: A surprise-down event is either of two cases. The first is a falling `link_up_i` while the drive is out of reset. The second is the filtered presence clearing while the link is up. With control bit 3 at 0, such an event pulses `sd_err_o` for one cycle and sets status bit 2. With control bit 3 at 1, neither happens.
- R9: Address 0 reads the capabilities: bit 0 is hot-plug capable and bit 1 is power controller present. Address 1 reads and writes control bits 3:0. Address 3 reads 0.
- R10: Status bit 5 follows `link_up_i` one edge later.
- R11: With no power controller fitted, power follows the filtered presence state without any software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prsnt_n_i | input | 1 | Raw presence pin, low when a drive is seated |
| link_up_i | input | 1 | In-band link-up indication |
| dual_port_i | input | 1 | Seated drive is dual-port |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| pwr_dis_o | output | 1 | Power disable to the drive |
| perst_n_o | output | 1 | Drive reset, active low |
| dual_port_en_o | output | 1 | Dual-port enable to the drive |
| sd_err_o | output | 1 | Surprise-down error pulse |
| irq_o | output | 1 | Slot interrupt |

## Verification
The bench sends a presence glitch one sample shorter than needed and counts edges precisely around the debounce threshold. A filter that is off by one, or that lacks a filter, would show presence too early or would react to the glitch. It times reset release to the exact edge and checks the two-step shutdown order. A sequencer that dropped power and reset together, or that released reset early, would fail those checks. Surprise-down is driven three ways: link loss in service, removal with the link up, and a software power-off followed by link loss. It is also driven with the hide bit set. A design that flagged an orderly power-off, or that ignored the hide bit, would pulse `sd_err_o` where it must stay low. A second instance with no hot-plug capability and no power controller confirms that events are suppressed and that power follows presence.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CAP  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_RSTWAIT = 2'd1,
    PS_ON      = 2'd2,
    PS_DRAIN   = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic hide_sd;
    logic pwr_on;
    logic lsc_en;
    logic pdc_en;
  } slot_ctrl_t;

  // sticky bits: clear the ones written as 1, new events win over clear
  function automatic logic [2:0] f_w1c(input logic [2:0] cur,
                                       input logic [2:0] clr,
                                       input logic [2:0] set);
    return (cur & ~clr) | set;
  endfunction

  // status word layout: [5] link, [4] presence, [2:0] sticky events
  function automatic logic [REG_W-1:0] f_stat_word(input logic link,
                                                   input logic pres,
                                                   input logic [2:0] sticky);
    return {2'b00, link, pres, 1'b0, sticky};
  endfunction

endpackage

// File: rtl/hp_presence_filter.sv
module hp_presence_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prsnt_n_i,
  output logic present_o,
  output logic change_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          raw_q;
  logic          present_q;
  logic          chg_q;
  logic [CW-1:0] cnt_q;
  logic          deb_hit;

  assign deb_hit = (cnt_q == CW'(DEB_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      present_q <= 1'b0;
      chg_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      raw_q <= ~prsnt_n_i;
      chg_q <= 1'b0;
      if (raw_q == present_q) begin
        cnt_q <= '0;
      end else if (deb_hit) begin
        present_q <= raw_q;
        chg_q     <= 1'b1;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign present_o = present_q;
  assign change_o  = chg_q;

  p_deb_follows_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (present_q != $past(present_q)) |-> (present_q == $past(raw_q)));

  p_chg_marks_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (present_q != $past(present_q)));

endmodule

// File: rtl/hp_power_seq.sv
module hp_power_seq
  import hp_slot_pkg::*;
#(
  parameter int RST_DELAY = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic present_i,
  input  logic power_ok_i,
  input  logic dual_port_i,
  output logic pwr_dis_o,
  output logic perst_n_o,
  output logic dual_en_o,
  output logic in_service_o
);
  localparam int CW = $clog2(RST_DELAY + 1);

  pwr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          want_on;

  assign want_on = present_i && power_ok_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_OFF:     if (want_on) st_d = PS_RSTWAIT;
      PS_RSTWAIT: if (!want_on) st_d = PS_DRAIN;
                  else if (cnt_q == CW'(RST_DELAY - 1)) st_d = PS_ON;
      PS_ON:      if (!want_on) st_d = PS_DRAIN;
      default:    st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == PS_RSTWAIT) ? cnt_q + 1'b1 : '0;
    end
  end

  assign pwr_dis_o    = (st_q == PS_OFF);
  assign perst_n_o    = (st_q == PS_ON);
  assign in_service_o = (st_q == PS_ON);
  assign dual_en_o    = ((st_q == PS_RSTWAIT) || (st_q == PS_ON)) && dual_port_i;

  p_rst_after_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> $past(!pwr_dis_o));

  p_cut_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dis_o) |-> $past(!perst_n_o));

  p_dual_needs_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en_o |-> !pwr_dis_o);

endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter bit HP_CAPABLE = 1'b1,
  parameter bit PWR_CTRL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             present_i,
  input  logic             pres_chg_i,
  input  logic             in_service_i,
  input  logic             link_up_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             power_ok_o,
  output logic             sd_err_o,
  output logic             irq_o
);
  slot_ctrl_t ctrl_q;
  logic [2:0] sticky_q;
  logic [2:0] set_evt;
  logic       link_q;
  logic       sd_err_q;
  logic       lsc_evt;
  logic       link_fall;
  logic       sd_evt;
  logic       stat_wr;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata_i[REG_W-1:4];

  assign lsc_evt   = link_q ^ link_up_i;
  assign link_fall = link_q & ~link_up_i;
  assign sd_evt    = (link_fall && in_service_i) || (pres_chg_i && !present_i && link_q);
  assign stat_wr   = reg_we_i && (reg_addr_i == ADDR_STAT);

  assign set_evt[0] = pres_chg_i && HP_CAPABLE && ctrl_q.pdc_en;
  assign set_evt[1] = lsc_evt && HP_CAPABLE && ctrl_q.lsc_en;
  assign set_evt[2] = sd_evt && !ctrl_q.hide_sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sticky_q <= '0;
      link_q   <= 1'b0;
      sd_err_q <= 1'b0;
    end else begin
      link_q   <= link_up_i;
      sd_err_q <= set_evt[2];
      if (reg_we_i && (reg_addr_i == ADDR_CTRL))
        ctrl_q <= slot_ctrl_t'(reg_wdata_i[3:0]);
      sticky_q <= f_w1c(sticky_q, stat_wr ? reg_wdata_i[2:0] : 3'b000, set_evt);
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CAP:  reg_rdata_o = {6'b0, PWR_CTRL, HP_CAPABLE};
      ADDR_CTRL: reg_rdata_o = {4'b0, ctrl_q};
      ADDR_STAT: reg_rdata_o = f_stat_word(link_q, present_i, sticky_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign power_ok_o = !PWR_CTRL || ctrl_q.pwr_on;
  assign sd_err_o   = sd_err_q;
  assign irq_o      = (sticky_q[0] && ctrl_q.pdc_en) || (sticky_q[1] && ctrl_q.lsc_en);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata_i[0] && !set_evt[0]) |=> !sticky_q[0]);

  p_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[1] && !(stat_wr && reg_wdata_i[1])) |=> sticky_q[1]);

  p_hidden_sd_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_err_q |-> !$past(ctrl_q.hide_sd));

  p_irq_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sticky_q[1:0] != 2'b00));

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int RST_DELAY  = 100,
  parameter bit HP_CAPABLE = 1'b1,
  parameter bit PWR_CTRL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prsnt_n_i,
  input  logic             link_up_i,
  input  logic             dual_port_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             pwr_dis_o,
  output logic             perst_n_o,
  output logic             dual_port_en_o,
  output logic             sd_err_o,
  output logic             irq_o
);
  logic present;
  logic pres_chg;
  logic power_ok;
  logic in_service;

  hp_presence_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .prsnt_n_i (prsnt_n_i),
    .present_o (present),
    .change_o  (pres_chg)
  );

  hp_power_seq #(.RST_DELAY(RST_DELAY)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .present_i    (present),
    .power_ok_i   (power_ok),
    .dual_port_i  (dual_port_i),
    .pwr_dis_o    (pwr_dis_o),
    .perst_n_o    (perst_n_o),
    .dual_en_o    (dual_port_en_o),
    .in_service_o (in_service)
  );

  hp_slot_regs #(.HP_CAPABLE(HP_CAPABLE), .PWR_CTRL(PWR_CTRL)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .present_i    (present),
    .pres_chg_i   (pres_chg),
    .in_service_i (in_service),
    .link_up_i    (link_up_i),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .power_ok_o   (power_ok),
    .sd_err_o     (sd_err_o),
    .irq_o        (irq_o)
  );

  p_service_implies_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (perst_n_o && !present) |=> !perst_n_o);

endmodule

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 16;
  localparam int RDLY = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       prsnt_a = 1'b1, link_a = 1'b0, dual_a = 1'b1, we_a = 1'b0;
  logic [1:0] addr_a = 2'd0;
  logic [7:0] wdata_a = 8'h00, rdata_a;
  logic       pwrdis_a, perst_a, dualen_a, sd_a, irq_a;

  logic       prsnt_b = 1'b1, we_b = 1'b0;
  logic [1:0] addr_b = 2'd0;
  logic [7:0] wdata_b = 8'h00, rdata_b;
  logic       pwrdis_b, perst_b, dualen_b, sd_b, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hp_slot_ctrl #(.DEB_CYCLES(DEB), .RST_DELAY(RDLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .prsnt_n_i(prsnt_a), .link_up_i(link_a),
    .dual_port_i(dual_a), .reg_we_i(we_a), .reg_addr_i(addr_a),
    .reg_wdata_i(wdata_a), .reg_rdata_o(rdata_a), .pwr_dis_o(pwrdis_a),
    .perst_n_o(perst_a), .dual_port_en_o(dualen_a), .sd_err_o(sd_a), .irq_o(irq_a));

  hp_slot_ctrl #(.DEB_CYCLES(DEB), .RST_DELAY(RDLY), .HP_CAPABLE(1'b0), .PWR_CTRL(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .prsnt_n_i(prsnt_b), .link_up_i(1'b0),
    .dual_port_i(1'b0), .reg_we_i(we_b), .reg_addr_i(addr_b),
    .reg_wdata_i(wdata_b), .reg_rdata_o(rdata_b), .pwr_dis_o(pwrdis_b),
    .perst_n_o(perst_b), .dual_port_en_o(dualen_b), .sd_err_o(sd_b), .irq_o(irq_b));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_a(input logic [1:0] a, input logic [7:0] d);
    we_a = 1'b1; addr_a = a; wdata_a = d;
    tick(1);
    we_a = 1'b0;
  endtask

  task automatic rd_a(input logic [1:0] a, output logic [7:0] d);
    addr_a = a; #1; d = rdata_a;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1", "pwr_dis", {7'b0, pwrdis_a}, 8'h01);
    chk("R1", "perst_n", {7'b0, perst_a}, 8'h00);
    chk("R1", "dual_en", {7'b0, dualen_a}, 8'h00);
    chk("R1", "sd/irq", {6'b0, sd_a, irq_a}, 8'h00);
    rd_a(2'd1, v); chk("R1", "ctrl", v, 8'h00);
    rd_a(2'd2, v); chk("R1", "status", v, 8'h00);
    rd_a(2'd0, v); chk("R9", "cap", v, 8'h03);
    rd_a(2'd3, v); chk("R9", "addr3", v, 8'h00);
  endtask

  task automatic t_glitch_and_insert;
    logic [7:0] v;
    wr_a(2'd1, 8'h03);
    rd_a(2'd1, v); chk("R9", "ctrl readback", v, 8'h03);
    prsnt_a = 1'b0; tick(DEB - 1); prsnt_a = 1'b1; tick(20);
    rd_a(2'd2, v); chk("R2", "glitch ignored", v, 8'h00);
    prsnt_a = 1'b0; tick(DEB);
    rd_a(2'd2, v); chk("R2", "not yet present", v[4], 1'b0);
    tick(1);
    rd_a(2'd2, v); chk("R2", "present", v, 8'h10);
    tick(1);
    rd_a(2'd2, v); chk("R6", "pdc set", v, 8'h11);
    chk("R7", "irq on pdc", {7'b0, irq_a}, 8'h01);
    chk("R3", "no power without pwr_on", {7'b0, pwrdis_a}, 8'h01);
    wr_a(2'd2, 8'h01);
    rd_a(2'd2, v); chk("R6", "w1c", v, 8'h10);
    chk("R7", "irq cleared", {7'b0, irq_a}, 8'h00);
  endtask

  task automatic t_power_up;
    wr_a(2'd1, 8'h07);
    chk("R3", "pwr_dis still set", {7'b0, pwrdis_a}, 8'h01);
    tick(1);
    chk("R3", "power on", {6'b0, pwrdis_a, perst_a}, 8'h00);
    chk("R5", "dual_en", {7'b0, dualen_a}, 8'h01);
    tick(RDLY - 1);
    chk("R3", "reset still held", {7'b0, perst_a}, 8'h00);
    tick(1);
    chk("R3", "reset released", {7'b0, perst_a}, 8'h01);
  endtask

  task automatic t_link;
    logic [7:0] v;
    link_a = 1'b1; tick(1);
    rd_a(2'd2, v); chk("R10", "link up status", v, 8'h32);
    chk("R7", "irq on lsc", {7'b0, irq_a}, 8'h01);
    wr_a(2'd2, 8'h02);
  endtask

  task automatic t_surprise_remove;
    logic [7:0] v;
    link_a = 1'b0; prsnt_a = 1'b1; tick(1);
    chk("R8", "sd pulse", {7'b0, sd_a}, 8'h01);
    rd_a(2'd2, v); chk("R8", "sd status", v, 8'h16);
    tick(1);
    chk("R8", "sd one cycle", {7'b0, sd_a}, 8'h00);
    tick(DEB - 2);
    chk("R4", "still in service", {7'b0, perst_a}, 8'h01);
    tick(1);
    chk("R4", "reset not yet", {7'b0, perst_a}, 8'h01);
    tick(1);
    chk("R4", "reset asserted", {6'b0, pwrdis_a, perst_a}, 8'h00);
    chk("R8", "no second sd", {7'b0, sd_a}, 8'h00);
    tick(1);
    chk("R4", "power cut", {7'b0, pwrdis_a}, 8'h01);
    chk("R5", "dual off", {7'b0, dualen_a}, 8'h00);
    wr_a(2'd2, 8'h07);
    rd_a(2'd2, v); chk("R6", "all cleared", v, 8'h00);
  endtask

  task automatic t_hidden;
    logic [7:0] v;
    wr_a(2'd1, 8'h0F);
    prsnt_a = 1'b0; tick(DEB + 2 + RDLY + 5);
    chk("R3", "reinserted", {7'b0, perst_a}, 8'h01);
    link_a = 1'b1; tick(1);
    wr_a(2'd2, 8'h07);
    link_a = 1'b0; tick(1);
    chk("R8", "hidden no pulse", {7'b0, sd_a}, 8'h00);
    rd_a(2'd2, v); chk("R8", "hidden no status", v, 8'h12);
    wr_a(2'd2, 8'h07);
  endtask

  task automatic t_sw_off_then_remove;
    logic [7:0] v;
    wr_a(2'd1, 8'h07);
    link_a = 1'b1; tick(2);
    wr_a(2'd1, 8'h03);
    tick(1);
    chk("R4", "sw off reset", {6'b0, pwrdis_a, perst_a}, 8'h00);
    tick(1);
    chk("R4", "sw off power", {7'b0, pwrdis_a}, 8'h01);
    chk("R8", "orderly off no sd", {7'b0, sd_a}, 8'h00);
    prsnt_a = 1'b1; tick(DEB + 1);
    chk("R8", "sd not before register", {7'b0, sd_a}, 8'h00);
    tick(1);
    chk("R8", "removal with link up", {7'b0, sd_a}, 8'h01);
    link_a = 1'b0; tick(2);
    chk("R8", "link loss when off", {7'b0, sd_a}, 8'h00);
    rd_a(2'd2, v); chk("R8", "sd status latched", v[2], 1'b1);
  endtask

  task automatic t_no_ctrl;
    logic [7:0] v;
    we_b = 1'b1; addr_b = 2'd1; wdata_b = 8'h03; tick(1); we_b = 1'b0;
    addr_b = 2'd0; #1; chk("R9", "cap b", rdata_b, 8'h00);
    prsnt_b = 1'b0; tick(DEB + 1);
    chk("R11", "not yet powered", {7'b0, pwrdis_b}, 8'h01);
    tick(1);
    chk("R11", "auto power", {7'b0, pwrdis_b}, 8'h00);
    chk("R5", "single port", {7'b0, dualen_b}, 8'h00);
    addr_b = 2'd2; #1; v = rdata_b;
    chk("R6", "incapable no event", v, 8'h10);
    chk("R7", "incapable no irq", {7'b0, irq_b}, 8'h00);
    tick(RDLY);
    chk("R11", "auto reset release", {7'b0, perst_b}, 8'h01);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_glitch_and_insert();
    t_power_up();
    t_link();
    t_surprise_remove();
    t_hidden();
    t_sw_off_then_remove();
    t_no_ctrl();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule